// File: doc/BRIEF.md
# Integer Instruction Decode and Execute Unit

This block takes one 32-bit instruction word together with the two register operand values already read for it, and produces, in the same cycle and without any storage, the value to be written back, the destination register index and a write enable. It recognises a fixed, small integer subset: register-register add, subtract, or, xor and the three shifts; add, and and or with a 12-bit immediate; and load-upper-immediate.

Everything outside that subset is flagged as illegal and never writes. The unit sits between the register file read and the writeback mux of a simple single-cycle datapath. Program counter logic, memory access and the register file are handled by neighbouring blocks.

Top module: `int_exec_unit`

## Requirements
- R1: The destination index output always equals instruction bits 11:7. The opcode is bits 6:0, funct3 is bits 14:12 and funct7 is bits 31:25.
- R2: Opcode 0110011 with funct3 000 gives operand A plus operand B when funct7 is 0000000, and A minus B when funct7 is 0100000 (bit 30 set). Results are modulo 2^32.
- R3: Opcode 0110011 with funct7 0000000 gives A OR B for funct3 110 and A XOR B for funct3 100.
- R4: Opcode 0110011 with funct3 001 and funct7 0000000 shifts A left. funct3 101 shifts A right, filling with zeros when funct7 is 0000000 and with the sign bit when funct7 is 0100000. Only bits 4:0 of B give the shift amount.
- R5: Opcode 0010011 with funct3 000 adds A to the sign-extended 12-bit immediate in bits 31:20.
- R6: Opcode 0010011 with funct3 111 gives A AND the zero-extended immediate. funct3 110 gives A OR the zero-extended immediate.
- R7: Opcode 0110111 gives the 20-bit field in bits 31:12 shifted left by 16, keeping the low 32 bits. Bits 15:0 of the result are zero.
- R8: Any other opcode, funct3 or funct7 combination raises the illegal flag, drives the write enable low and drives the result to zero.
- R9: The write enable is high for every legal instruction whose destination index is not zero, and low whenever the destination index is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | First source register value |
| opb_i | input | 32 | Second source register value |
| result_o | output | 32 | Computed writeback value |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Instruction outside the supported subset |

## Verification
The hardest conditions to reach are the near-miss encodings. These are words with a legal opcode but a funct7 that differs by one bit, a funct3 used by the other group, or a second operand whose upper bits would change the shift if they were not ignored. A uniformly random word almost never hits them. The stimulus therefore builds most instructions from a legal class, then corrupts funct7 or funct3 with a set probability. It also forces the destination index to zero in some vectors and uses operands with large upper bits. Directed vectors add the extreme shift amounts, the most negative immediate and an all-ones upper field.

// File: rtl/int_exec_pkg.sv
// Shared opcodes, operation codes and decode bundle for the execute unit.
// Assumes the fixed 32-bit instruction layout with a 7-bit opcode field.
package int_exec_pkg;
    localparam int INSTR_W = 32;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_UPPER = 7'b0110111;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_OR,
        OP_XOR,
        OP_AND,
        OP_SHL,
        OP_SHR_ZERO,
        OP_SHR_SIGN,
        OP_PASS_B
    } exec_op_e;

    typedef enum logic [1:0] {
        SRC_REG,
        SRC_IMM_SIGNED,
        SRC_IMM_ZERO,
        SRC_UPPER
    } src_sel_e;

    typedef struct packed {
        exec_op_e op;
        src_sel_e src;
        logic     legal;
    } dec_ctrl_t;
endpackage

// File: rtl/iexu_field_split.sv
// Slices an instruction into its fields and builds the three immediate forms.
// Assumes UP_SHIFT < DATA_W; the upper immediate keeps only the low DATA_W bits.
module iexu_field_split
    import int_exec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter int UP_SHIFT = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output logic [6:0]         opcode,
    output logic [2:0]         funct3,
    output logic [6:0]         funct7,
    output logic [IDX_W-1:0]   rd,
    output logic [DATA_W-1:0]  imm_sext,
    output logic [DATA_W-1:0]  imm_zext,
    output logic [DATA_W-1:0]  imm_upper
);
    localparam int IMM_W = 12;
    localparam int UP_W  = 20;
    localparam int WIDE_W = UP_W + UP_SHIFT;

    logic [IMM_W-1:0]  imm12;
    logic [UP_W-1:0]   up20;
    logic [WIDE_W-1:0] up_wide;

    // Field extraction at the fixed bit positions.
    always_comb begin
        opcode = instr[6:0];
        rd     = instr[7 +: IDX_W];
        funct3 = instr[14:12];
        funct7 = instr[31:25];
        imm12  = instr[31:20];
        up20   = instr[31:12];
        up_wide = {up20, {UP_SHIFT{1'b0}}};
    end

    // Immediate extension; the upper form is truncated or padded to DATA_W.
    always_comb begin
        imm_sext = {{(DATA_W-IMM_W){imm12[IMM_W-1]}}, imm12};
        imm_zext = {{(DATA_W-IMM_W){1'b0}}, imm12};
    end

    generate
        if (WIDE_W >= DATA_W) begin : g_up_trunc
            assign imm_upper = up_wide[DATA_W-1:0];
        end else begin : g_up_pad
            assign imm_upper = {{(DATA_W-WIDE_W){1'b0}}, up_wide};
        end
    endgenerate
endmodule

// File: rtl/iexu_ctrl.sv
// Maps opcode, funct3 and funct7 to an operation, an operand-B source and
// a legality bit. Assumes nothing about the register operands.
module iexu_ctrl
    import int_exec_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output dec_ctrl_t  ctrl
);
    logic f7_zero;
    logic f7_alt;

    // Only two funct7 patterns exist in the subset.
    always_comb begin
        f7_zero = (funct7 == 7'b0000000);
        f7_alt  = (funct7 == 7'b0100000);
    end

    // Operation selection per group; anything unmatched stays illegal.
    always_comb begin
        ctrl = '{op: OP_NONE, src: SRC_REG, legal: 1'b0};
        unique case (opcode)
            OPC_REG: begin
                ctrl.src = SRC_REG;
                case (funct3)
                    3'b000: if (f7_zero) ctrl = '{OP_ADD, SRC_REG, 1'b1};
                            else if (f7_alt) ctrl = '{OP_SUB, SRC_REG, 1'b1};
                    3'b110: if (f7_zero) ctrl = '{OP_OR, SRC_REG, 1'b1};
                    3'b100: if (f7_zero) ctrl = '{OP_XOR, SRC_REG, 1'b1};
                    3'b001: if (f7_zero) ctrl = '{OP_SHL, SRC_REG, 1'b1};
                    3'b101: if (f7_zero) ctrl = '{OP_SHR_ZERO, SRC_REG, 1'b1};
                            else if (f7_alt) ctrl = '{OP_SHR_SIGN, SRC_REG, 1'b1};
                    default: ;
                endcase
            end
            OPC_IMM: begin
                case (funct3)
                    3'b000: ctrl = '{OP_ADD, SRC_IMM_SIGNED, 1'b1};
                    3'b111: ctrl = '{OP_AND, SRC_IMM_ZERO, 1'b1};
                    3'b110: ctrl = '{OP_OR, SRC_IMM_ZERO, 1'b1};
                    default: ;
                endcase
            end
            OPC_UPPER: ctrl = '{OP_PASS_B, SRC_UPPER, 1'b1};
            default: ;
        endcase
    end
endmodule

// File: rtl/iexu_alu.sv
// Combinational arithmetic, logic and shift datapath.
// Assumes DATA_W is a power of two so the shift amount is log2(DATA_W) bits.
module iexu_alu
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  exec_op_e          op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;

    // Shift amount from the low bits of operand B only.
    always_comb shamt = b[SH_W-1:0];

    // Result mux over the supported operations.
    always_comb begin
        unique case (op)
            OP_ADD:      y = a + b;
            OP_SUB:      y = a - b;
            OP_OR:       y = a | b;
            OP_XOR:      y = a ^ b;
            OP_AND:      y = a & b;
            OP_SHL:      y = a << shamt;
            OP_SHR_ZERO: y = a >> shamt;
            OP_SHR_SIGN: y = DATA_W'($signed(a) >>> shamt);
            OP_PASS_B:   y = b;
            default:     y = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
// Top of the decode/execute unit: field split, control decode, operand-B
// select and ALU, then write-enable and illegal qualification.
// Assumes operands arrive already read from the register file.
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 5,
    parameter int UP_SHIFT = 16
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    output logic [DATA_W-1:0]  result_o,
    output logic [IDX_W-1:0]   rd_o,
    output logic               wr_en_o,
    output logic               illegal_o
);
    logic [6:0]        opcode;
    logic [2:0]        funct3;
    logic [6:0]        funct7;
    logic [IDX_W-1:0]  rd;
    logic [DATA_W-1:0] imm_sext, imm_zext, imm_upper;
    logic [DATA_W-1:0] opb_sel, alu_y;
    dec_ctrl_t         ctrl;

    iexu_field_split #(.DATA_W(DATA_W), .IDX_W(IDX_W), .UP_SHIFT(UP_SHIFT)) u_split (
        .instr(instr_i), .opcode(opcode), .funct3(funct3), .funct7(funct7),
        .rd(rd), .imm_sext(imm_sext), .imm_zext(imm_zext), .imm_upper(imm_upper)
    );

    iexu_ctrl u_ctrl (
        .opcode(opcode), .funct3(funct3), .funct7(funct7), .ctrl(ctrl)
    );

    // Operand-B source: register or one of the immediate forms.
    always_comb begin
        unique case (ctrl.src)
            SRC_REG:        opb_sel = opb_i;
            SRC_IMM_SIGNED: opb_sel = imm_sext;
            SRC_IMM_ZERO:   opb_sel = imm_zext;
            default:        opb_sel = imm_upper;
        endcase
    end

    iexu_alu #(.DATA_W(DATA_W)) u_alu (
        .op(ctrl.op), .a(opa_i), .b(opb_sel), .y(alu_y)
    );

    // Output qualification: illegal zeroes the result, index zero never writes.
    always_comb begin
        rd_o      = rd;
        illegal_o = ~ctrl.legal;
        result_o  = ctrl.legal ? alu_y : '0;
        wr_en_o   = ctrl.legal && (rd != '0);
    end
endmodule

// File: rtl/int_exec_unit_chk.sv
// Property checker for int_exec_unit, attached by bind. Uses immediate
// assertions because the unit is purely combinational.
module int_exec_unit_chk
    import int_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  opa_i,
    input logic [DATA_W-1:0]  opb_i,
    input logic [DATA_W-1:0]  result_o,
    input logic [IDX_W-1:0]   rd_o,
    input logic               wr_en_o,
    input logic               illegal_o
);
    // Cross-checks between outputs and the instruction fields.
    always_comb begin
        if (illegal_o) begin
            assert_illegal_quiet_R8: assert (!wr_en_o && result_o == '0)
                else $error("illegal instruction wrote or produced data");
        end
        if (rd_o == '0) begin
            assert_no_write_x0_R9: assert (!wr_en_o)
                else $error("write enabled for index zero");
        end
        if (instr_i[6:0] == OPC_UPPER) begin
            assert_upper_low_clear_R7: assert (result_o[15:0] == 16'h0 && !illegal_o)
                else $error("upper immediate low half not clear");
        end
        if (instr_i[6:0] == OPC_IMM && instr_i[14:12] == 3'b111) begin
            assert_andi_high_clear_R6: assert (result_o[DATA_W-1:12] == '0)
                else $error("and-immediate high bits set");
        end
        if (instr_i[6:0] == OPC_REG && instr_i[14:12] == 3'b001
            && instr_i[31:25] == 7'b0) begin
            assert_shl_low5_R4: assert (result_o == (opa_i << opb_i[4:0]))
                else $error("left shift amount wrong");
        end
    end
endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .instr_i(instr_i), .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o),
    .rd_o(rd_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr, opa, opb;
    logic [31:0] result;
    logic [4:0]  rd;
    logic        wr_en, illegal;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    int_exec_unit u_dut (
        .instr_i(instr), .opa_i(opa), .opb_i(opb), .result_o(result),
        .rd_o(rd), .wr_en_o(wr_en), .illegal_o(illegal)
    );

    // Independent model: returns expected result, legality and requirement tag.
    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic ok, output string tag);
        logic [6:0]  oc = ins[6:0];
        logic [2:0]  f3 = ins[14:12];
        logic [6:0]  f7 = ins[31:25];
        logic [11:0] im = ins[31:20];
        int          sh = b % 32;
        ok = 1'b1; r = 32'h0; tag = "R8";
        if (oc == 7'h33 && f3 == 3'd0 && f7 == 7'h00) begin r = a + b; tag = "R2"; end
        else if (oc == 7'h33 && f3 == 3'd0 && f7 == 7'h20) begin r = a - b; tag = "R2"; end
        else if (oc == 7'h33 && f3 == 3'd6 && f7 == 7'h00) begin r = a | b; tag = "R3"; end
        else if (oc == 7'h33 && f3 == 3'd4 && f7 == 7'h00) begin r = a ^ b; tag = "R3"; end
        else if (oc == 7'h33 && f3 == 3'd1 && f7 == 7'h00) begin r = a << sh; tag = "R4"; end
        else if (oc == 7'h33 && f3 == 3'd5 && f7 == 7'h00) begin r = a >> sh; tag = "R4"; end
        else if (oc == 7'h33 && f3 == 3'd5 && f7 == 7'h20) begin
            r = a >> sh;
            for (int i = 0; i < 32; i++) if (i >= 32 - sh && a[31]) r[i] = 1'b1;
            tag = "R4";
        end
        else if (oc == 7'h13 && f3 == 3'd0) begin r = a + {{20{im[11]}}, im}; tag = "R5"; end
        else if (oc == 7'h13 && f3 == 3'd7) begin r = a & {20'h0, im}; tag = "R6"; end
        else if (oc == 7'h13 && f3 == 3'd6) begin r = a | {20'h0, im}; tag = "R6"; end
        else if (oc == 7'h37) begin r = {ins[27:12], 16'h0}; tag = "R7"; end
        else ok = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s instr=%h act=%h exp=%h", tag, instr, act, exp);
        end
    endtask

    // Apply one vector on the falling edge and compare one time unit later.
    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic        eok;
        string       tg;
        @(negedge clk);
        instr = ins; opa = a; opb = b;
        #1;
        model(ins, a, b, er, eok, tg);
        check("R1", {27'h0, rd}, {27'h0, ins[11:7]});
        check("R8", {31'h0, illegal}, {31'h0, !eok});
        check("R9", {31'h0, wr_en}, {31'h0, eok && ins[11:7] != 5'd0});
        check(tg, result, er);
    endtask

    function automatic logic [31:0] enc(input int cls, input logic [31:0] rnd, input logic [4:0] rdi);
        logic [31:0] w = rnd;
        w[11:7] = rdi;
        case (cls)
            0: begin w[6:0] = 7'h33; w[14:12] = 3'd0; w[31:25] = 7'h00; end
            1: begin w[6:0] = 7'h33; w[14:12] = 3'd0; w[31:25] = 7'h20; end
            2: begin w[6:0] = 7'h33; w[14:12] = 3'd6; w[31:25] = 7'h00; end
            3: begin w[6:0] = 7'h33; w[14:12] = 3'd4; w[31:25] = 7'h00; end
            4: begin w[6:0] = 7'h33; w[14:12] = 3'd1; w[31:25] = 7'h00; end
            5: begin w[6:0] = 7'h33; w[14:12] = 3'd5; w[31:25] = 7'h00; end
            6: begin w[6:0] = 7'h33; w[14:12] = 3'd5; w[31:25] = 7'h20; end
            7: begin w[6:0] = 7'h13; w[14:12] = 3'd0; end
            8: begin w[6:0] = 7'h13; w[14:12] = 3'd7; end
            9: begin w[6:0] = 7'h13; w[14:12] = 3'd6; end
            10: w[6:0] = 7'h37;
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        int          unused_seed;
        logic [31:0] w;
        unused_seed = $urandom(32'd2024);
        instr = 32'h0; opa = 32'h0; opb = 32'h0;
        repeat (3) @(posedge clk);
        // Reset state: all-zero word is illegal and silent (R8).
        @(negedge clk); #1;
        check("R8", {31'h0, illegal}, 32'h1);
        check("R8", {31'h0, wr_en}, 32'h0);
        rst_n = 1'b1;

        // Directed corners.
        apply(enc(6, 32'h0, 5'd3), 32'h8000_0000, 32'd31);      // R4 sign fill full
        apply(enc(5, 32'h0, 5'd3), 32'h8000_0000, 32'd31);      // R4 zero fill
        apply(enc(4, 32'h0, 5'd4), 32'h0000_0001, 32'hFFFF_FFE3); // R4 low 5 bits only
        apply({12'h800, 5'd1, 3'd0, 5'd5, 7'h13}, 32'd100, 32'd0); // R5 -2048
        apply({12'hFFF, 5'd1, 3'd7, 5'd6, 7'h13}, 32'hFFFF_FFFF, 32'd0); // R6 zero-ext
        apply({12'hFFF, 5'd1, 3'd6, 5'd6, 7'h13}, 32'h1234_0000, 32'd0); // R6 or-imm
        apply({20'hFFFFF, 5'd7, 7'h37}, 32'd0, 32'd0);          // R7 truncation
        apply({20'h00005, 5'd7, 7'h37}, 32'd0, 32'd0);          // R7 0x50000
        apply(enc(1, 32'h0, 5'd9), 32'd0, 32'd1);               // R2 wrap to all ones
        apply(enc(0, 32'h0, 5'd0), 32'd5, 32'd6);               // R9 index zero
        apply({7'h20, 10'h0, 3'd6, 5'd2, 7'h33}, 32'd1, 32'd2); // R8 or with alt funct7
        apply({7'h01, 10'h0, 3'd0, 5'd2, 7'h33}, 32'd1, 32'd2); // R8 stray funct7 bit
        apply({12'h0, 5'd0, 3'd1, 5'd2, 7'h13}, 32'd1, 32'd2);  // R8 unsupported imm funct3
        apply({20'h1, 5'd2, 7'h17}, 32'd1, 32'd2);              // R8 unknown opcode

        // Constrained random mix.
        for (int n = 0; n < 3000; n++) begin
            int cls = $urandom_range(0, 12);
            w = enc(cls, $urandom, (($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom)));
            if ($urandom_range(0, 9) == 0) w[31:25] = w[31:25] ^ (7'h1 << $urandom_range(0, 6));
            if ($urandom_range(0, 14) == 0) w[14:12] = 3'($urandom);
            apply(w, $urandom, $urandom);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog expired act=running exp=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule